// File: doc/BRIEF.md
# Cycle Timestamp Generator With Gap Overflow

This block runs a free counter that advances on every clock edge and stamps each transaction summary record with that counter's low bits. Next to the counter it keeps a saturating tracker of the cycles since the last accepted record. When a record is produced and that gap has reached 2^TS_W cycles or more, the record's overflow bit is set. A set overflow bit means the stamp cannot be used to measure the interval, because the stamp field alone would have wrapped.

The caller pulses `rec_stb` in the cycle a summary record is being formed. One cycle later `rec_vld` pulses, and `rec_ts` and `rec_ovf` carry the fields for that record. The full counter is also driven on `cnt_out` continuously, for trigger-time capture. A cold reset reinitialises everything. A warm reset leaves the counter and the gap tracker alone. It clears the record output and suppresses any record requested while it is held.

Top module: `cycle_stamp_gen`

## Requirements
- R1: `cnt_out` is 0 in the cycle after a cold reset and then grows by exactly one every clock cycle, wrapping modulo 2^CNT_W.
- R2: A strobe accepted in cycle N (`rec_stb`=1, both resets low) gives `rec_vld`=1 in cycle N+1 only. In that cycle `rec_ts` equals the low TS_W bits that `cnt_out` showed in cycle N.
- R3: Elapsed time is the difference of the counter values at two consecutive accepted strobes. `rec_ovf` is 1 when this difference is 2^TS_W or more and 0 when it is smaller, including at exactly 2^TS_W-1.
- R4: The gap tracker saturates, so a gap of many times 2^TS_W cycles still reports `rec_ovf`=1.
- R5: For the first record after a cold reset, elapsed time is counted from the reset. `rec_ovf` is 0 if the counter shows less than 2^TS_W at the strobe and 1 otherwise.
- R6: An accepted strobe restarts the gap measurement in its own cycle. Strobes on consecutive cycles always give `rec_ovf`=0.
- R7: While `rst_warm` is 1, the counter and the gap tracker keep running unchanged. In the following cycle `rec_vld`, `rec_ts` and `rec_ovf` are 0. A strobe in a warm-reset cycle produces no record and does not restart the gap.
- R8: A cold reset forces `cnt_out`, `rec_vld`, `rec_ts` and `rec_ovf` to 0 and the gap to zero, and it wins over a strobe in the same cycle.
- R9: Between records, `rec_ts` and `rec_ovf` hold the fields of the last record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_cold | input | 1 | Synchronous active-high cold reset of all state |
| rst_warm | input | 1 | Synchronous active-high warm reset; clears record output only |
| rec_stb | input | 1 | Summary record is being formed this cycle |
| rec_vld | output | 1 | One-cycle pulse: record fields are valid |
| rec_ts | output | TS_W | Timestamp field of the record |
| rec_ovf | output | 1 | Gap since previous record reached 2^TS_W cycles |
| cnt_out | output | CNT_W | Free-running cycle counter |

## Verification
The assertions assume that `rst_cold` is asserted at least once before the first checked edge. Each property is armed only after the checker has seen a cold reset, and the bench applies one at time zero. They also take `rec_stb` and `rst_warm` to be clean synchronous levels that are held across a whole cycle. The bench changes them only on the falling edge. The stimulus sweeps every record gap from 1 to well past 2^TS_W with a 4-bit stamp. It mixes in warm resets, and it applies cold resets both alone and together with strobes.

// File: rtl/cycle_stamp_pkg.sv
package cycle_stamp_pkg;

  localparam int unsigned DEF_TS_W  = 23;
  localparam int unsigned DEF_CNT_W = 32;

  typedef enum logic [1:0] {
    CTL_RUN  = 2'd0,
    CTL_WARM = 2'd1,
    CTL_COLD = 2'd2
  } stamp_ctl_e;

  function automatic stamp_ctl_e decode_ctl(input logic cold, input logic warm);
    if (cold)      return CTL_COLD;
    else if (warm) return CTL_WARM;
    else           return CTL_RUN;
  endfunction

endpackage

// File: rtl/cycle_free_counter.sv
module cycle_free_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_cold,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst_cold) cnt_q <= '0;
    else          cnt_q <= cnt_q + ONE;
  end

endmodule

// File: rtl/cycle_gap_tracker.sv
module cycle_gap_tracker #(
  parameter int unsigned TS_W = 23
) (
  input  logic clk,
  input  logic rst_cold,
  input  logic acc_stb,
  output logic gap_full
);

  localparam int unsigned     GAP_W = TS_W + 1;
  localparam logic [GAP_W-1:0] LIMIT = GAP_W'(1) << TS_W;
  localparam logic [GAP_W-1:0] ONE   = GAP_W'(1);

  logic [GAP_W-1:0] gap_q;
  logic             at_limit;

  assign at_limit = gap_q[GAP_W-1];

  always_ff @(posedge clk) begin
    if (rst_cold)      gap_q <= '0;
    else if (acc_stb)  gap_q <= ONE;
    else if (at_limit) gap_q <= LIMIT;
    else               gap_q <= gap_q + ONE;
  end

  assign gap_full = at_limit;

endmodule

// File: rtl/cycle_record_reg.sv
module cycle_record_reg
  import cycle_stamp_pkg::*;
#(
  parameter int unsigned TS_W = 23
) (
  input  logic            clk,
  input  logic            rst_cold,
  input  logic            rst_warm,
  input  logic            acc_stb,
  input  logic [TS_W-1:0] ts_in,
  input  logic            ovf_in,
  output logic            vld_q,
  output logic [TS_W-1:0] ts_q,
  output logic            ovf_q
);

  stamp_ctl_e ctl;
  assign ctl = decode_ctl(rst_cold, rst_warm);

  always_ff @(posedge clk) begin
    case (ctl)
      CTL_COLD, CTL_WARM: begin
        vld_q <= 1'b0;
        ts_q  <= '0;
        ovf_q <= 1'b0;
      end
      default: begin
        vld_q <= acc_stb;
        if (acc_stb) begin
          ts_q  <= ts_in;
          ovf_q <= ovf_in;
        end
      end
    endcase
  end

endmodule

// File: rtl/cycle_stamp_gen.sv
module cycle_stamp_gen
  import cycle_stamp_pkg::*;
#(
  parameter int unsigned TS_W  = DEF_TS_W,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_cold,
  input  logic             rst_warm,
  input  logic             rec_stb,
  output logic             rec_vld,
  output logic [TS_W-1:0]  rec_ts,
  output logic             rec_ovf,
  output logic [CNT_W-1:0] cnt_out
);

  generate
    if (CNT_W < TS_W) begin : g_bad_width
      $error("CNT_W must be at least TS_W");
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q;
  logic             acc_stb;
  logic             gap_full;

  assign acc_stb = rec_stb & ~rst_warm & ~rst_cold;

  cycle_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_cold (rst_cold),
    .cnt_q    (cnt_q)
  );

  cycle_gap_tracker #(.TS_W(TS_W)) u_gap (
    .clk      (clk),
    .rst_cold (rst_cold),
    .acc_stb  (acc_stb),
    .gap_full (gap_full)
  );

  cycle_record_reg #(.TS_W(TS_W)) u_rec (
    .clk      (clk),
    .rst_cold (rst_cold),
    .rst_warm (rst_warm),
    .acc_stb  (acc_stb),
    .ts_in    (cnt_q[TS_W-1:0]),
    .ovf_in   (gap_full),
    .vld_q    (rec_vld),
    .ts_q     (rec_ts),
    .ovf_q    (rec_ovf)
  );

  assign cnt_out = cnt_q;

endmodule

// File: rtl/cycle_stamp_gen_chk.sv
module cycle_stamp_gen_chk #(
  parameter int unsigned TS_W  = 23,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_cold,
  input logic             rst_warm,
  input logic             rec_stb,
  input logic             rec_vld,
  input logic [TS_W-1:0]  rec_ts,
  input logic             rec_ovf,
  input logic [CNT_W-1:0] cnt_out
);

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_cold) armed <= 1'b1;
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst_cold)
    armed && !$past(rst_cold) |-> cnt_out == $past(cnt_out) + CNT_W'(1));

  assert_stamp_value_R2: assert property (@(posedge clk) disable iff (rst_cold)
    armed && rec_vld |-> rec_ts == $past(cnt_out[TS_W-1:0]));

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (rst_cold)
    armed && rec_vld && $past(rec_vld) |-> !rec_ovf);

  assert_warm_blocks_R7: assert property (@(posedge clk) disable iff (rst_cold)
    armed && rst_warm |=> !rec_vld && !rec_ovf);

  assert_cold_clears_R8: assert property (@(posedge clk) disable iff (rst_cold)
    armed && $past(rst_cold) |-> cnt_out == '0 && !rec_vld && !rec_ovf);

  assert_hold_fields_R9: assert property (@(posedge clk) disable iff (rst_cold)
    armed && !rec_vld && !$past(rst_cold) && !$past(rst_warm)
      |-> $stable(rec_ts) && $stable(rec_ovf));

endmodule

bind cycle_stamp_gen cycle_stamp_gen_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_cold (rst_cold),
  .rst_warm (rst_warm),
  .rec_stb  (rec_stb),
  .rec_vld  (rec_vld),
  .rec_ts   (rec_ts),
  .rec_ovf  (rec_ovf),
  .cnt_out  (cnt_out)
);

// File: tb/cycle_stamp_gen_test.sv
`timescale 1ns/1ps
module cycle_stamp_gen_test;

  localparam int TS_W  = 4;
  localparam int CNT_W = 8;
  localparam int LIM   = 1 << TS_W;

  logic             clk = 1'b0;
  logic             rst_cold = 1'b1;
  logic             rst_warm = 1'b0;
  logic             rec_stb = 1'b0;
  logic             rec_vld;
  logic [TS_W-1:0]  rec_ts;
  logic             rec_ovf;
  logic [CNT_W-1:0] cnt_out;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  int mcnt = 0;
  int last = 0;
  int e_vld = 0, e_ts = 0, e_ovf = 0;

  always #2.5 clk = ~clk;

  cycle_stamp_gen #(.TS_W(TS_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .rec_stb(rec_stb),
    .rec_vld(rec_vld), .rec_ts(rec_ts), .rec_ovf(rec_ovf), .cnt_out(cnt_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit stb, input bit warm, input bit cold, input string otag);
    @(negedge clk);
    rec_stb = stb; rst_warm = warm; rst_cold = cold;
    @(posedge clk);
    if (cold) begin
      mcnt = 0; last = 0; e_vld = 0; e_ts = 0; e_ovf = 0;
    end else begin
      if (warm) begin
        e_vld = 0; e_ts = 0; e_ovf = 0;
      end else if (stb) begin
        e_vld = 1; e_ts = mcnt % LIM; e_ovf = ((mcnt - last) >= LIM) ? 1 : 0;
        last = mcnt;
      end else begin
        e_vld = 0;
      end
      mcnt++;
    end
    #1;
    chk(int'(cnt_out) == (mcnt % (1 << CNT_W)), warm ? "R7 counter" : (cold ? "R8 counter" : "R1 counter"),
        int'(cnt_out), mcnt % (1 << CNT_W));
    chk(int'(rec_vld) == e_vld, "R2 valid", int'(rec_vld), e_vld);
    chk(int'(rec_ts) == e_ts, e_vld ? "R2 stamp" : "R9 stamp hold", int'(rec_ts), e_ts);
    chk(int'(rec_ovf) == e_ovf, otag, int'(rec_ovf), e_ovf);
  endtask

  task automatic idle(input int n, input string otag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, otag);
  endtask

  initial begin
    // R8: reset state
    step(1'b0, 1'b0, 1'b1, "R8 ovf");
    step(1'b1, 1'b0, 1'b1, "R8 ovf");
    // R5: first record at count LIM-1 -> no overflow
    idle(LIM - 1, "R9 ovf hold");
    step(1'b1, 1'b0, 1'b0, "R5 first record short");
    idle(2, "R9 ovf hold");
    // R5: first record at count LIM -> overflow
    step(1'b0, 1'b0, 1'b1, "R8 ovf");
    idle(LIM, "R9 ovf hold");
    step(1'b1, 1'b0, 1'b0, "R5 first record long");
    // R3 / R6: sweep every gap 1..3*LIM
    for (int g = 1; g <= 3 * LIM; g++) begin
      idle(g - 1, "R9 ovf hold");
      step(1'b1, 1'b0, 1'b0, (g == 1) ? "R6 back to back" : "R3 gap");
    end
    // R4: very long gap, saturating tracker
    idle(7 * LIM, "R9 ovf hold");
    step(1'b1, 1'b0, 1'b0, "R4 saturated gap");
    step(1'b1, 1'b0, 1'b0, "R6 restart after long");
    // R7: warm strobe must not restart the gap
    idle(9, "R9 ovf hold");
    step(1'b1, 1'b1, 1'b0, "R7 warm clears");
    step(1'b0, 1'b1, 1'b0, "R7 warm clears");
    idle(LIM - 12, "R7 ovf");
    step(1'b1, 1'b0, 1'b0, "R7 gap spans warm");
    idle(3, "R7 ovf");
    step(1'b1, 1'b0, 1'b0, "R3 short after warm");
    // R8: cold reset together with strobe
    idle(LIM + 2, "R9 ovf hold");
    step(1'b1, 1'b0, 1'b1, "R8 cold wins");
    step(1'b1, 1'b0, 1'b0, "R5 right after reset");
    idle(20, "R9 ovf hold");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule